// File: doc/BRIEF.md
# Integer Add/Subtract/Divide/Shift Unit with Carry and Overflow Flags

This block is a 32-bit integer arithmetic unit. It offers the add and subtract-from families, negate, signed and unsigned division and three shift forms. It keeps three architectural flags: carry, overflow and a sticky summary-overflow. Each operation is picked by a 4-bit opcode. A per-operation overflow-enable bit decides whether the overflow flags are written. Every operation finishes in one cycle except a regular divide, which runs through a bit-serial restoring divider for one cycle per quotient bit.

Operations enter on a valid/ready stream (`in_valid`/`in_ready`) and results leave on another (`out_valid`/`out_ready`). The unit holds at most one operation at a time. `in_ready` is low while a result waits to be taken and while a divide is in progress. A result that has been presented stays on `out_res`, unchanged, until `out_ready` takes it. The flags are plain status pins that show the flag registers at all times. They change on the same clock edge that raises `out_valid`. A separate clear pin zeroes all three flags.

Top module: `alu_core`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1 and the carry, overflow and summary-overflow flags are all 0.
- R2: Opcodes are: 0 add, 1 add carrying, 2 add extended (a+b+carry), 3 add-to-minus-one extended (a+all-ones+carry), 4 add-to-zero extended (a+carry), 5 subtract-from (b-a), 6 subtract-from carrying, 7 subtract-from extended (b+~a+carry), 8 subtract-from minus-one extended (~a+all-ones+carry), 9 subtract-from zero extended (~a+carry), 10 negate, 11 signed divide a/b truncated toward zero, 12 unsigned divide, 13 shift left by b, 14 logical shift right by b, 15 arithmetic shift right by `in_imm`. Each opcode returns the 32-bit result that wraps modulo 2^32.
- R3: Opcodes 1-4 and 6-9 set carry to the carry out of bit 31 of their 33-bit sum. With carry-in 1, a result equal to the first addend therefore counts as a carry. Opcodes 0, 5, 10-14 leave carry unchanged.
- R4: When `in_ovf_en` is 1 on opcodes 0-12, overflow takes the signed-overflow outcome of the operation and summary-overflow is ORed with it (it stays set). When `in_ovf_en` is 0, or for opcodes 13-15, both flags keep their values.
- R5: Negating 0x80000000 returns 0x80000000 and counts as overflow. Every other value returns its two's complement with no overflow.
- R6: A signed divide by zero, or 0x80000000 divided by -1, returns all ones when the dividend is negative and zero otherwise, and counts as overflow. Other signed divides do not overflow.
- R7: An unsigned divide by zero returns zero and counts as overflow. Other unsigned divides return the floor quotient and do not overflow.
- R8: Opcodes 13 and 14 shift by `in_b[4:0]` but return zero whenever `in_b[5]` (0x20) is 1.
- R9: Opcode 15 sets carry to 1 only when the operand is negative and at least one 1 bit was shifted out. Otherwise it sets carry to 0.
- R10: A non-divide operation, or a divide that hits R6/R7's special cases, presents its result one cycle after acceptance. A regular divide presents its result 33 cycles after acceptance, and `in_ready` stays low in between.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_res` holds its value.
- R12: A cycle with `flags_clr` high zeroes carry, overflow and summary-overflow on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flags_clr | input | 1 | Zero all three flags |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_op | input | 4 | Opcode (see R2) |
| in_ovf_en | input | 1 | Allow overflow flag update |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand / shift amount |
| in_imm | input | 5 | Immediate shift amount for opcode 15 |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes result |
| out_res | output | 32 | Result |
| ca_o | output | 1 | Carry flag |
| ov_o | output | 1 | Overflow flag |
| so_o | output | 1 | Summary-overflow flag |

## Verification
The checks assume that `flags_clr` is never raised in the same cycle that an operation is accepted or a divide completes. They also assume that the divider is only started while it is idle, which the top guarantees by keeping `in_ready` low while busy. The stimulus raises `flags_clr` only after the scoreboard has drained, so no operation is in flight. It offers operations only at falling edges where `in_ready` is observed high. The random phase toggles `out_ready` at rising edges so that back-pressure falls on every stage of the single-cycle and divide paths.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_ADDE  = 4'd2,
    OP_ADDM1 = 4'd3,
    OP_ADDZ  = 4'd4,
    OP_SUB   = 4'd5,
    OP_SUBC  = 4'd6,
    OP_SUBE  = 4'd7,
    OP_SUBM1 = 4'd8,
    OP_SUBZ  = 4'd9,
    OP_NEG   = 4'd10,
    OP_DIVS  = 4'd11,
    OP_DIVU  = 4'd12,
    OP_SHL   = 4'd13,
    OP_SHR   = 4'd14,
    OP_SRAI  = 4'd15
  } alu_op_e;

  function automatic logic writes_carry(alu_op_e op);
    return op inside {OP_ADDC, OP_ADDE, OP_ADDM1, OP_ADDZ,
                      OP_SUBC, OP_SUBE, OP_SUBM1, OP_SUBZ};
  endfunction

  function automatic logic can_overflow(alu_op_e op);
    return !(op inside {OP_SHL, OP_SHR, OP_SRAI});
  endfunction
endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] x, y;
  logic         ci;

  // Every add/subtract-from form is x + y + ci on one adder.
  always_comb begin
    x  = a;
    y  = b;
    ci = 1'b0;
    unique case (op)
      OP_ADD, OP_ADDC: begin x = a;  y = b;    ci = 1'b0; end
      OP_ADDE:         begin x = a;  y = b;    ci = cin;  end
      OP_ADDM1:        begin x = a;  y = '1;   ci = cin;  end
      OP_ADDZ:         begin x = a;  y = '0;   ci = cin;  end
      OP_SUB, OP_SUBC: begin x = ~a; y = b;    ci = 1'b1; end
      OP_SUBE:         begin x = ~a; y = b;    ci = cin;  end
      OP_SUBM1:        begin x = ~a; y = '1;   ci = cin;  end
      OP_SUBZ:         begin x = ~a; y = '0;   ci = cin;  end
      OP_NEG:          begin x = ~a; y = '0;   ci = 1'b1; end
      default:         begin x = a;  y = b;    ci = 1'b0; end
    endcase
  end

  always_comb begin
    {cout, sum} = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    ovf = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
  end
endmodule

// File: rtl/alu_shift.sv
`timescale 1ns/1ps
module alu_shift
  import alu_pkg::*;
#(
  parameter int W = 32,
  localparam int SH = $clog2(W)
) (
  input  alu_op_e       op,
  input  logic [W-1:0]  a,
  input  logic [SH:0]   amt,
  input  logic [SH-1:0] imm,
  output logic [W-1:0]  res,
  output logic          cout
);
  logic [W-1:0] lost_mask;

  always_comb begin
    lost_mask = ~({W{1'b1}} << imm);
    cout      = 1'b0;
    unique case (op)
      OP_SHL:  res = amt[SH] ? '0 : (a << amt[SH-1:0]);
      OP_SHR:  res = amt[SH] ? '0 : (a >> amt[SH-1:0]);
      OP_SRAI: begin
        res  = W'($signed(a) >>> imm);
        cout = a[W-1] && (|(a & lost_mask));
      end
      default: res = a;
    endcase
  end
endmodule

// File: rtl/alu_divider.sv
`timescale 1ns/1ps
module alu_divider #(
  parameter int W = 32,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);
  logic [W-1:0]  rem_q, quo_q, dsr_q;
  logic [CW-1:0] cnt_q;
  logic [W:0]    shifted, trial;

  // One quotient bit per cycle: shift in the next dividend bit, try subtracting.
  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, dsr_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= dividend;
        dsr_q <= divisor;
        cnt_q <= CW'(W - 1);
        busy  <= 1'b1;
      end else if (busy) begin
        if (trial[W]) begin
          rem_q <= shifted[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end else begin
          rem_q <= trial[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo_q;

  assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  assert_done_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core
  import alu_pkg::*;
#(
  parameter int W = 32,
  localparam int SH = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flags_clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_op,
  input  logic          in_ovf_en,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [SH-1:0] in_imm,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_res,
  output logic          ca_o,
  output logic          ov_o,
  output logic          so_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  alu_op_e      op;
  logic         ca_q, ov_q, so_q;
  logic         ca_n, ov_n, so_n;
  logic [W-1:0] as_sum, sh_res, comb_res, sp_res, dvd, dsr, quo;
  logic         as_cout, as_ovf, sh_cout;
  logic         is_sdiv, is_div, div_special, accept, div_start, single_done;
  logic         div_busy, div_done, neg_q, dv_ovf_q;

  assign op = alu_op_e'(in_op);

  alu_addsub #(.W(W)) u_addsub (
    .op(op), .a(in_a), .b(in_b), .cin(ca_q),
    .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
  );

  alu_shift #(.W(W)) u_shift (
    .op(op), .a(in_a), .amt(in_b[SH:0]), .imm(in_imm),
    .res(sh_res), .cout(sh_cout)
  );

  // Division corner cases resolve in one cycle; the rest go to the divider.
  always_comb begin
    is_sdiv     = (op == OP_DIVS);
    is_div      = is_sdiv || (op == OP_DIVU);
    div_special = is_div && ((in_b == '0) ||
                  (is_sdiv && in_a == MOST_NEG && in_b == '1));
    sp_res      = is_sdiv ? {W{in_a[W-1]}} : '0;
    dvd         = (is_sdiv && in_a[W-1]) ? ('0 - in_a) : in_a;
    dsr         = (is_sdiv && in_b[W-1]) ? ('0 - in_b) : in_b;
  end

  assign in_ready    = !out_valid && !div_busy && !div_done;
  assign accept      = in_valid && in_ready;
  assign div_start   = accept && is_div && !div_special;
  assign single_done = accept && !div_start;

  alu_divider #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .dividend(dvd), .divisor(dsr),
    .busy(div_busy), .done(div_done), .quotient(quo)
  );

  always_comb begin
    if (op inside {OP_SHL, OP_SHR, OP_SRAI}) comb_res = sh_res;
    else if (is_div)                         comb_res = sp_res;
    else                                     comb_res = as_sum;
  end

  // Flag next-state: carry per carrying opcode, overflow only when enabled.
  always_comb begin
    ca_n = ca_q;
    ov_n = ov_q;
    so_n = so_q;
    if (single_done) begin
      if (writes_carry(op))  ca_n = as_cout;
      else if (op == OP_SRAI) ca_n = sh_cout;
      if (in_ovf_en && can_overflow(op)) begin
        if (is_div) begin
          ov_n = 1'b1;
          so_n = 1'b1;
        end else begin
          ov_n = as_ovf;
          so_n = so_q | as_ovf;
        end
      end
    end
    if (div_done && dv_ovf_q) ov_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca_q <= 1'b0;
      ov_q <= 1'b0;
      so_q <= 1'b0;
    end else if (flags_clr) begin
      ca_q <= 1'b0;
      ov_q <= 1'b0;
      so_q <= 1'b0;
    end else begin
      ca_q <= ca_n;
      ov_q <= ov_n;
      so_q <= so_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
      neg_q     <= 1'b0;
      dv_ovf_q  <= 1'b0;
    end else begin
      if (div_start) begin
        neg_q    <= is_sdiv && (in_a[W-1] ^ in_b[W-1]);
        dv_ovf_q <= in_ovf_en;
      end
      if (single_done) begin
        out_res   <= comb_res;
        out_valid <= 1'b1;
      end else if (div_done) begin
        out_res   <= neg_q ? ('0 - quo) : quo;
        out_valid <= 1'b1;
      end else if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign ca_o = ca_q;
  assign ov_o = ov_q;
  assign so_o = so_q;

  assert_ov_in_so_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ov_q |-> so_q);
  assert_so_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    so_q && !flags_clr |=> so_q);
  assert_neg_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_NEG && in_a == MOST_NEG |=> out_res == MOST_NEG);
  assert_shift_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (op == OP_SHL || op == OP_SHR) && in_b[SH] |=> out_res == '0);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res));
  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    flags_clr |=> !ca_q && !ov_q && !so_q);
endmodule

// File: tb/alu_core_bench.sv
`timescale 1ns/1ps
module alu_core_bench;
  localparam logic [31:0] MINV = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flags_clr = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic        in_ovf_en = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic [4:0]  in_imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_res;
  logic        ca_o, ov_o, so_o;

  int tests = 0;
  int fails = 0;
  bit bp_on = 1'b0;
  logic [31:0] bp_lfsr = 32'h1234_5678;
  logic [31:0] rnd = 32'hC0FF_EE11;

  logic        m_ca = 1'b0, m_ov = 1'b0, m_so = 1'b0;
  logic [31:0] q_res[$];
  logic [2:0]  q_flg[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  alu_core u_alu_core (
    .clk(clk), .rst_n(rst_n), .flags_clr(flags_clr),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_ovf_en(in_ovf_en), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .ca_o(ca_o), .ov_o(ov_o), .so_o(so_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirement text.
  task automatic model(input logic [3:0] op, input bit oe, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] imm,
                       output logic [31:0] r);
    logic [31:0] x, y;
    logic ci, c, v;
    longint u, s;
    x = a; y = b; ci = 1'b0; c = m_ca; v = 1'b0; r = '0;
    case (op)
      4'd0, 4'd1: begin x = a;  y = b;   ci = 1'b0; end
      4'd2:       begin x = a;  y = b;   ci = m_ca; end
      4'd3:       begin x = a;  y = '1;  ci = m_ca; end
      4'd4:       begin x = a;  y = '0;  ci = m_ca; end
      4'd5, 4'd6: begin x = ~a; y = b;   ci = 1'b1; end
      4'd7:       begin x = ~a; y = b;   ci = m_ca; end
      4'd8:       begin x = ~a; y = '1;  ci = m_ca; end
      4'd9:       begin x = ~a; y = '0;  ci = m_ca; end
      default: ;
    endcase
    if (op <= 4'd9) begin
      u = longint'(x) + longint'(y) + longint'(ci);
      s = longint'($signed(x)) + longint'($signed(y)) + longint'(ci);
      r = u[31:0];
      v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      if (op != 4'd0 && op != 4'd5) c = u[32];
    end else begin
      case (op)
        4'd10: begin r = (a == MINV) ? a : (32'd0 - a); v = (a == MINV); end
        4'd11: begin
          if (b == 0 || (a == MINV && b == '1)) begin r = {32{a[31]}}; v = 1'b1; end
          else r = 32'($signed(a) / $signed(b));
        end
        4'd12: begin
          if (b == 0) begin r = '0; v = 1'b1; end
          else r = a / b;
        end
        4'd13: r = b[5] ? '0 : (a << b[4:0]);
        4'd14: r = b[5] ? '0 : (a >> b[4:0]);
        default: begin
          r = 32'($signed(a) >>> imm);
          c = a[31] && ((a & ((32'h1 << imm) - 32'h1)) != 0);
        end
      endcase
    end
    m_ca = c;
    if (oe && op <= 4'd12) begin
      m_ov = v;
      m_so = m_so | v;
    end
  endtask

  // Driver: compute expectation, push it, offer the operation at a falling edge.
  task automatic send(input logic [3:0] op, input bit oe, input logic [31:0] a,
                      input logic [31:0] b, input logic [4:0] imm, input string tag);
    logic [31:0] r;
    model(op, oe, a, b, imm, r);
    q_res.push_back(r);
    q_flg.push_back({m_ca, m_ov, m_so});
    q_tag.push_back(tag);
    while (!in_ready) @(negedge clk);
    in_op = op; in_ovf_en = oe; in_a = a; in_b = b; in_imm = imm;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q_res.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pop and compare whenever a result is taken.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (q_res.size() == 0) begin
        check(1'b0, "R10 unexpected result", out_res, 32'h0);
      end else begin
        logic [31:0] er;
        logic [2:0]  ef;
        string       t;
        er = q_res.pop_front();
        ef = q_flg.pop_front();
        t  = q_tag.pop_front();
        check(out_res == er, {t, " result"}, out_res, er);
        check({ca_o, ov_o, so_o} == ef, {t, " flags ca/ov/so"},
              {29'd0, ca_o, ov_o, so_o}, {29'd0, ef});
      end
    end
  end

  always @(posedge clk) begin
    if (bp_on) begin
      bp_lfsr   <= {bp_lfsr[30:0], bp_lfsr[31] ^ bp_lfsr[21] ^ bp_lfsr[1] ^ bp_lfsr[0]};
      out_ready <= bp_lfsr[3] | bp_lfsr[7];
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog R10", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1 handshake after reset",
          {30'd0, out_valid, in_ready}, 32'h1);
    check({ca_o, ov_o, so_o} == 3'b000, "R1 flags after reset",
          {29'd0, ca_o, ov_o, so_o}, 32'h0);

    // R2 plain forms and R10 single-cycle latency
    send(4'd0, 1'b0, 32'd5, 32'd7, 5'd0, "R2 add");
    check(out_valid == 1'b1, "R10 one-cycle latency", {31'd0, out_valid}, 32'h1);
    send(4'd5, 1'b0, 32'd3, 32'd10, 5'd0, "R2 subf");
    send(4'd5, 1'b0, 32'd10, 32'd3, 5'd0, "R2 subf negative");
    // R3 carry rules
    send(4'd1, 1'b0, 32'hFFFF_FFFF, 32'd1, 5'd0, "R3 addc wrap");
    send(4'd0, 1'b0, 32'hFFFF_FFFF, 32'd2, 5'd0, "R3 add keeps carry");
    send(4'd2, 1'b0, 32'hFFFF_FFFF, 32'd0, 5'd0, "R3 adde equal result carries");
    send(4'd3, 1'b0, 32'd0, 32'd0, 5'd0, "R3 addme zero operand");
    send(4'd3, 1'b0, 32'd0, 32'd0, 5'd0, "R3 addme no carry-in");
    send(4'd4, 1'b0, 32'hFFFF_FFFF, 32'd0, 5'd0, "R3 addze");
    send(4'd6, 1'b0, 32'd5, 32'd5, 5'd0, "R3 subfc equal");
    send(4'd7, 1'b0, 32'd9, 32'd4, 5'd0, "R3 subfe");
    send(4'd8, 1'b0, 32'hFFFF_FFFF, 32'd0, 5'd0, "R3 subfme");
    send(4'd9, 1'b0, 32'd0, 32'd0, 5'd0, "R3 subfze");
    // R4 overflow and sticky summary
    send(4'd0, 1'b0, 32'h7FFF_FFFF, 32'd1, 5'd0, "R4 overflow ignored when disabled");
    send(4'd0, 1'b1, 32'h7FFF_FFFF, 32'd1, 5'd0, "R4 add overflow");
    send(4'd0, 1'b1, 32'd1, 32'd1, 5'd0, "R4 ov clears so sticks");
    send(4'd6, 1'b1, 32'd1, 32'h8000_0000, 5'd0, "R4 subfc overflow");
    send(4'd5, 1'b0, 32'd1, 32'd2, 5'd0, "R4 disabled keeps ov");
    send(4'd13, 1'b1, 32'd1, 32'd1, 5'd0, "R4 shift keeps ov");
    // R5 negate
    send(4'd10, 1'b1, MINV, 32'd0, 5'd0, "R5 negate most negative");
    send(4'd10, 1'b1, 32'd5, 32'd0, 5'd0, "R5 negate five");
    send(4'd10, 1'b0, MINV, 32'd0, 5'd0, "R5 negate no ovf mode");
    drain();
    // R12 clear
    flags_clr = 1'b1;
    @(negedge clk);
    flags_clr = 1'b0;
    check({ca_o, ov_o, so_o} == 3'b000, "R12 flags cleared",
          {29'd0, ca_o, ov_o, so_o}, 32'h0);
    m_ca = 1'b0; m_ov = 1'b0; m_so = 1'b0;
    // R6 signed divide
    send(4'd11, 1'b1, 32'hFFFF_FFF9, 32'd2, 5'd0, "R6 -7/2");
    send(4'd11, 1'b1, 32'd7, 32'hFFFF_FFFE, 5'd0, "R6 7/-2");
    send(4'd11, 1'b1, MINV, 32'hFFFF_FFFF, 5'd0, "R6 min/-1");
    send(4'd11, 1'b1, 32'd5, 32'd0, 5'd0, "R6 positive/0");
    send(4'd11, 1'b0, 32'hFFFF_FFFB, 32'd0, 5'd0, "R6 negative/0");
    send(4'd11, 1'b1, MINV, 32'd2, 5'd0, "R6 min/2");
    // R7 unsigned divide
    send(4'd12, 1'b1, 32'd100, 32'd7, 5'd0, "R7 100/7");
    send(4'd12, 1'b1, 32'hFFFF_FFFF, 32'd1, 5'd0, "R7 max/1");
    send(4'd12, 1'b1, 32'd77, 32'd0, 5'd0, "R7 divide by zero");
    // R8 shifts
    send(4'd13, 1'b0, 32'h0000_00F1, 32'd4, 5'd0, "R8 shl 4");
    send(4'd13, 1'b0, 32'hFFFF_FFFF, 32'h20, 5'd0, "R8 shl 0x20");
    send(4'd13, 1'b0, 32'hFFFF_FFFF, 32'h21, 5'd0, "R8 shl 0x21");
    send(4'd14, 1'b0, 32'h8000_0000, 32'd31, 5'd0, "R8 shr 31");
    send(4'd14, 1'b0, 32'hFFFF_FFFF, 32'h3F, 5'd0, "R8 shr 0x3f");
    // R9 arithmetic shift carry
    send(4'd15, 1'b0, 32'hFFFF_FFF8, 32'd0, 5'd2, "R9 -8 sra 2");
    send(4'd15, 1'b0, 32'hFFFF_FFF9, 32'd0, 5'd1, "R9 -7 sra 1");
    send(4'd15, 1'b0, 32'd7, 32'd0, 5'd1, "R9 7 sra 1");
    send(4'd15, 1'b0, 32'hFFFF_FFFF, 32'd0, 5'd0, "R9 sra 0");
    drain();
    // R10 divide latency and input stall
    send(4'd12, 1'b0, 32'd1000, 32'd10, 5'd0, "R10 divide");
    lat = 0;
    while (!out_valid && lat < 100) begin
      @(negedge clk);
      lat++;
      if (lat == 3) check(in_ready == 1'b0, "R10 in_ready low while dividing",
                          {31'd0, in_ready}, 32'h0);
    end
    check(lat == 33, "R10 divide latency", 32'(lat), 32'd33);
    drain();
    // R11 back-pressure hold
    out_ready = 1'b0;
    send(4'd0, 1'b0, 32'd40, 32'd2, 5'd0, "R11 held add");
    held = out_res;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b1 && out_res == held, "R11 hold under back-pressure",
          out_res, held);
    check(in_ready == 1'b0, "R11 no accept while held", {31'd0, in_ready}, 32'h0);
    out_ready = 1'b1;
    drain();
    // Random mix with random back-pressure
    bp_on = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] ra, rb;
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      ra = rnd;
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      rb = (rnd[30:28] == 3'd0) ? {26'd0, rnd[5:0]} : rnd;
      if (rnd[27:25] == 3'd0) ra = MINV;
      send(rnd[3:0], rnd[4], ra, rb, rnd[12:8], "R2 R3 R4 random mix");
    end
    drain();
    bp_on = 1'b0;
    @(negedge clk);
    out_ready = 1'b1;
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule